// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a single-bus processor datapath. Each clock it emits one control word, where every bit drives exactly one datapath strobe: a register driving or loading the internal bus, an ALU operation, a memory read request, or sequencing flags. The words come from a microprogram store computed at elaboration time. A micro-program counter steps through consecutive words, and a dispatch stage turns the opcode field of the instruction register into the start address of the matching execute routine.

Every machine instruction starts with a shared three-word fetch routine. In the cycle after the instruction register is loaded, the sequencer takes its address from the opcode instead of the counter and moves into the execute routine. The routine runs until a word carries the End bit, and the next cycle is fetch again. A word that waits for memory holds the sequencer until the memory-complete input is high. In a conditional branch, a failed condition ends the routine at its first word, so the program counter is left as it is.

Top module: `useq_ctrl`

## Requirements
- R1: The control word `cw` bit positions are: 0 pc_out, 1 pc_in, 2 mar_in, 3 mdr_out, 4 ir_in, 5 ir_out, 6 r1_out, 7 r1_in, 8 y_in, 9 y_clear, 10 z_in, 11 z_out, 12 alu_add, 13 carry_in, 14 mem_read, 15 wait_mem, 16 end. While `rst_n` is low, `cw` is the first fetch word.
- R2: Fetch is three words in this order: {pc_out, mar_in, mem_read, y_clear, carry_in, alu_add, z_in}, then {z_out, pc_in, wait_mem}, then {mdr_out, ir_in}.
- R3: A word with wait_mem set is repeated each cycle while `mfc` is low, and the sequencer moves on in the cycle after `mfc` is sampled high. `mfc` has no effect on any other word.
- R4: Opcode 1 (add from memory) runs {ir_out, mar_in, mem_read}, {r1_out, y_in, wait_mem}, {mdr_out, alu_add, z_in}, {z_out, r1_in, end}. The opcode is taken in the cycle after the ir_in word.
- R5: Opcode 2 branches always, opcode 3 branches when `flags[0]` is 1, and opcode 4 branches when `flags[1]` is 1. A taken branch runs {pc_out, y_in}, {ir_out, alu_add, z_in}, {z_out, pc_in, end}.
- R6: If the branch condition is false in the {pc_out, y_in} cycle, that word is output with end also set and the next word is the first fetch word. `flags` are ignored in every other cycle.
- R7: The cycle after any word with end set outputs the first fetch word. Opcodes 0 and 5 to 15 run a single word holding only end.
- R8: At most one of the bus drivers pc_out, mdr_out, ir_out, r1_out and z_out is set in any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, returns to fetch |
| opcode | input | OPC_W (4) | Opcode field of the instruction register |
| flags | input | FLAG_W (2) | Condition flags: bit 0 zero, bit 1 negative |
| mfc | input | 1 | Memory operation complete |
| cw | output | 17 | Control word, one strobe per bit |

## Verification
The bound checker checks on every cycle that at most one bus driver is on, that a waiting word stays unchanged while memory has not answered, and that an End word is followed by the fetch entry. It also checks that fetch word one leads to word two, that the add opcode is taken right after the instruction register loads, and that a failed zero-flag test ends the routine. The scoreboard is the only way to show the full word order of each routine under varied stall lengths. It also shows that `mfc` and the flags outside the test cycle have no effect, that each branch opcode picks the right flag, that unknown opcodes run a single word, and that a reset in the middle of a routine goes back to fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;
   // control word bit positions (datapath decodes these)
   localparam int B_PC_OUT   = 0;
   localparam int B_PC_IN    = 1;
   localparam int B_MAR_IN   = 2;
   localparam int B_MDR_OUT  = 3;
   localparam int B_IR_IN    = 4;
   localparam int B_IR_OUT   = 5;
   localparam int B_R1_OUT   = 6;
   localparam int B_R1_IN    = 7;
   localparam int B_Y_IN     = 8;
   localparam int B_Y_CLR    = 9;
   localparam int B_Z_IN     = 10;
   localparam int B_Z_OUT    = 11;
   localparam int B_ADD      = 12;
   localparam int B_CIN      = 13;
   localparam int B_READ     = 14;
   localparam int B_WAIT     = 15;
   localparam int B_END      = 16;
   localparam int CW_W       = 17;
   // sequencer-only bits kept in the store, never driven out
   localparam int B_MAP      = 17;
   localparam int B_TEST     = 18;
   localparam int UW_W       = 19;

   // microroutine entry points
   localparam int A_FETCH    = 0;
   localparam int A_ADD      = 3;
   localparam int A_BRANCH   = 7;
   localparam int A_NOP      = 10;
   localparam int A_LAST     = 10;

   // opcode values
   localparam int OP_ADD     = 1;
   localparam int OP_BR_LO   = 2;

   function automatic logic [UW_W-1:0] ucode(input int a);
      logic [UW_W-1:0] w;
      w = '0;
      case (a)
         0: begin
            w[B_PC_OUT] = 1'b1; w[B_MAR_IN] = 1'b1; w[B_READ] = 1'b1;
            w[B_Y_CLR]  = 1'b1; w[B_CIN]    = 1'b1; w[B_ADD]  = 1'b1;
            w[B_Z_IN]   = 1'b1;
         end
         1: begin
            w[B_Z_OUT] = 1'b1; w[B_PC_IN] = 1'b1; w[B_WAIT] = 1'b1;
         end
         2: begin
            w[B_MDR_OUT] = 1'b1; w[B_IR_IN] = 1'b1; w[B_MAP] = 1'b1;
         end
         3: begin
            w[B_IR_OUT] = 1'b1; w[B_MAR_IN] = 1'b1; w[B_READ] = 1'b1;
         end
         4: begin
            w[B_R1_OUT] = 1'b1; w[B_Y_IN] = 1'b1; w[B_WAIT] = 1'b1;
         end
         5: begin
            w[B_MDR_OUT] = 1'b1; w[B_ADD] = 1'b1; w[B_Z_IN] = 1'b1;
         end
         6: begin
            w[B_Z_OUT] = 1'b1; w[B_R1_IN] = 1'b1; w[B_END] = 1'b1;
         end
         7: begin
            w[B_PC_OUT] = 1'b1; w[B_Y_IN] = 1'b1; w[B_TEST] = 1'b1;
         end
         8: begin
            w[B_IR_OUT] = 1'b1; w[B_ADD] = 1'b1; w[B_Z_IN] = 1'b1;
         end
         9: begin
            w[B_Z_OUT] = 1'b1; w[B_PC_IN] = 1'b1; w[B_END] = 1'b1;
         end
         10: w[B_END] = 1'b1;
         default: w[B_END] = 1'b1;
      endcase
      return w;
   endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0]   addr,
   output logic [UW_W-1:0] word
);
   localparam int DEPTH = 1 << AW;

   generate
      if (DEPTH <= A_LAST) begin : g_bad_depth
         $error("useq_store: AW too small for the microprogram");
      end
   endgenerate

   logic [UW_W-1:0] rom [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         assign rom[i] = ucode(i);
      end
   endgenerate

   assign word = rom[addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
   import useq_pkg::*;
#(
   parameter int OPC_W  = 4,
   parameter int FLAG_W = 2,
   parameter int AW     = 5
) (
   input  logic [OPC_W-1:0] opcode,
   output logic [AW-1:0]    start,
   output logic [$clog2(FLAG_W+1)-1:0] sel
);
   localparam int SEL_W = $clog2(FLAG_W + 1);
   localparam int BR_HI = OP_BR_LO + FLAG_W;

   generate
      if (BR_HI >= (1 << OPC_W)) begin : g_bad_opc
         $error("useq_dispatch: opcode field too narrow for branch set");
      end
   endgenerate

   int unsigned op_i;

   always_comb begin
      op_i  = int'(opcode);
      start = AW'(A_NOP);
      sel   = '0;
      if (op_i == OP_ADD) begin
         start = AW'(A_ADD);
      end else if (op_i >= OP_BR_LO && op_i <= BR_HI) begin
         start = AW'(A_BRANCH);
         sel   = SEL_W'(op_i - OP_BR_LO);
      end
   end
endmodule

// File: rtl/useq_cond.sv
module useq_cond #(
   parameter int FLAG_W = 2
) (
   input  logic [$clog2(FLAG_W+1)-1:0] sel,
   input  logic [FLAG_W-1:0]           flags,
   output logic                        ok
);
   localparam int NCAND = FLAG_W + 1;

   logic [NCAND-1:0] cand;

   assign cand[0] = 1'b1;
   generate
      for (genvar k = 1; k < NCAND; k++) begin : g_cand
         assign cand[k] = flags[k-1];
      end
   endgenerate

   always_comb begin
      ok = 1'b0;
      for (int k = 0; k < NCAND; k++) begin
         if (int'(sel) == k) ok = cand[k];
      end
   end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int OPC_W  = 4,
   parameter int FLAG_W = 2,
   parameter int AW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [FLAG_W-1:0] flags,
   input  logic              mfc,
   output logic [CW_W-1:0]   cw
);
   localparam int SEL_W = $clog2(FLAG_W + 1);

   generate
      if (FLAG_W < 1) begin : g_bad_flags
         $error("useq_ctrl: need at least one flag");
      end
   endgenerate

   logic [AW-1:0]    upc_q;
   logic             map_q;
   logic [AW-1:0]    start;
   logic [SEL_W-1:0] sel;
   logic             cond_ok;
   logic [AW-1:0]    addr;
   logic [UW_W-1:0]  word;
   logic             stall;
   logic             test_fail;
   logic             finish;

   useq_dispatch #(.OPC_W(OPC_W), .FLAG_W(FLAG_W), .AW(AW)) u_disp (
      .opcode (opcode),
      .start  (start),
      .sel    (sel)
   );

   useq_cond #(.FLAG_W(FLAG_W)) u_cond (
      .sel   (sel),
      .flags (flags),
      .ok    (cond_ok)
   );

   assign addr = map_q ? start : upc_q;

   useq_store #(.AW(AW)) u_store (
      .addr (addr),
      .word (word)
   );

   assign stall     = word[B_WAIT] & ~mfc;
   assign test_fail = word[B_TEST] & ~cond_ok;
   assign finish    = word[B_END] | test_fail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upc_q <= AW'(A_FETCH);
         map_q <= 1'b0;
      end else if (stall) begin
         upc_q <= addr;
         map_q <= 1'b0;
      end else if (finish) begin
         upc_q <= AW'(A_FETCH);
         map_q <= 1'b0;
      end else if (word[B_MAP]) begin
         upc_q <= addr;
         map_q <= 1'b1;
      end else begin
         upc_q <= addr + AW'(1);
         map_q <= 1'b0;
      end
   end

   always_comb begin
      cw        = word[CW_W-1:0];
      cw[B_END] = finish;
   end
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
   import useq_pkg::*;
#(
   parameter int OPC_W  = 4,
   parameter int FLAG_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OPC_W-1:0]  opcode,
   input logic [FLAG_W-1:0] flags,
   input logic              mfc,
   input logic [CW_W-1:0]   cw
);
   logic [CW_W-1:0] fetch_one;
   logic [CW_W-1:0] add_one;

   always_comb begin
      fetch_one = '0;
      fetch_one[B_PC_OUT] = 1'b1; fetch_one[B_MAR_IN] = 1'b1;
      fetch_one[B_READ]   = 1'b1; fetch_one[B_Y_CLR]  = 1'b1;
      fetch_one[B_CIN]    = 1'b1; fetch_one[B_ADD]    = 1'b1;
      fetch_one[B_Z_IN]   = 1'b1;
      add_one = '0;
      add_one[B_IR_OUT] = 1'b1; add_one[B_MAR_IN] = 1'b1;
      add_one[B_READ]   = 1'b1;
   end

   assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cw[B_PC_OUT], cw[B_MDR_OUT], cw[B_IR_OUT], cw[B_R1_OUT], cw[B_Z_OUT]}));

   assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cw[B_WAIT] && !mfc) |=> $stable(cw));

   assert_end_refetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cw[B_END] |=> (cw == fetch_one));

   assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cw == fetch_one) |=> (cw[B_Z_OUT] && cw[B_PC_IN] && cw[B_WAIT]));

   assert_add_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cw[B_IR_IN] ##1 (opcode == OPC_W'(OP_ADD)) |-> (cw == add_one));

   assert_branch_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cw[B_PC_OUT] && cw[B_Y_IN] && opcode == OPC_W'(3) && !flags[0]) |-> cw[B_END]);
endmodule

bind useq_ctrl useq_ctrl_chk #(.OPC_W(OPC_W), .FLAG_W(FLAG_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .opcode (opcode),
   .flags  (flags),
   .mfc    (mfc),
   .cw     (cw)
);

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;
   localparam int W = 17;

   typedef struct {
      logic [W-1:0] exp;
      string        req;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   opcode = '0;
   logic [1:0]   flags = '0;
   logic         mfc = 1'b0;
   logic [W-1:0] cw;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;
   item_t sb[$];

   always #2.5 clk = ~clk;

   useq_ctrl u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .flags  (flags),
      .mfc    (mfc),
      .cw     (cw)
   );

   function automatic logic [W-1:0] mk(input int b0, b1 = -1, b2 = -1, b3 = -1,
                                       b4 = -1, b5 = -1, b6 = -1);
      logic [W-1:0] v;
      int bl[7];
      v  = '0;
      bl = '{b0, b1, b2, b3, b4, b5, b6};
      foreach (bl[i]) if (bl[i] >= 0) v[bl[i]] = 1'b1;
      return v;
   endfunction

   // R1 bit map: 0 pc_out 1 pc_in 2 mar_in 3 mdr_out 4 ir_in 5 ir_out 6 r1_out
   // 7 r1_in 8 y_in 9 y_clear 10 z_in 11 z_out 12 add 13 cin 14 read 15 wait 16 end
   logic [W-1:0] F1, F2, F3, A1, A2, A3, A4, B1, B2, B3, NOPW, B1X;
   initial begin
      F1   = mk(0, 2, 14, 9, 13, 12, 10);
      F2   = mk(11, 1, 15);
      F3   = mk(3, 4);
      A1   = mk(5, 2, 14);
      A2   = mk(6, 8, 15);
      A3   = mk(3, 12, 10);
      A4   = mk(11, 7, 16);
      B1   = mk(0, 8);
      B2   = mk(5, 12, 10);
      B3   = mk(11, 1, 16);
      NOPW = mk(16);
      B1X  = mk(0, 8, 16);
   end

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: cw actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   // monitor: pops one expected word per cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(cw, it.exp, it.req);
            total++;
            if (!$onehot0({cw[0], cw[3], cw[5], cw[6], cw[11]})) begin
               bad++;
               $display("FAIL R8: drivers actual=%05h expected at most one", cw);
            end
         end
      end
   end

   // driver: one cycle of stimulus plus its expected word
   task automatic cyc(input logic [3:0] op, input logic [1:0] fl, input logic m,
                      input logic [W-1:0] exp, input string req);
      item_t it;
      opcode = op;
      flags  = fl;
      mfc    = m;
      it.exp = exp;
      it.req = req;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic fetch(input logic [3:0] op, input logic [1:0] fl, input int f2s,
                        input logic idle);
      cyc(op, fl, idle, F1, "R2");
      for (int i = 0; i < f2s; i++) cyc(op, fl, 1'b0, F2, "R3");
      cyc(op, fl, 1'b1, F2, "R2");
      cyc(op, fl, idle, F3, "R2");
   endtask

   task automatic run(input logic [3:0] op, input logic [1:0] fl, input int f2s,
                      input int a2s, input logic idle);
      logic [1:0] other;
      logic taken;
      other = ~fl;
      fetch(op, other, f2s, idle);
      if (op == 4'd1) begin
         cyc(op, other, idle, A1, "R4");
         for (int i = 0; i < a2s; i++) cyc(op, other, 1'b0, A2, "R3");
         cyc(op, other, 1'b1, A2, "R4");
         cyc(op, other, idle, A3, "R4");
         cyc(op, other, idle, A4, "R4");
      end else if (op >= 4'd2 && op <= 4'd4) begin
         taken = (op == 4'd2) ? 1'b1 : (op == 4'd3) ? fl[0] : fl[1];
         if (taken) begin
            cyc(op, fl, idle, B1, "R5");
            cyc(op, other, idle, B2, "R5");
            cyc(op, other, idle, B3, "R5");
         end else begin
            cyc(op, fl, idle, B1X, "R6");
         end
      end else begin
         cyc(op, other, idle, NOPW, "R7");
      end
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      check(cw, F1, "R1");
      @(negedge clk);
      rst_n = 1'b1;

      run(4'd1, 2'b00, 0, 0, 1'b0);      // R4 plain add
      run(4'd1, 2'b11, 2, 3, 1'b1);      // R3 stalls, mfc high elsewhere
      run(4'd2, 2'b00, 1, 0, 1'b1);      // R5 always
      run(4'd3, 2'b01, 0, 0, 1'b0);      // R5 zero taken
      run(4'd3, 2'b10, 0, 0, 1'b1);      // R6 zero not taken
      run(4'd4, 2'b10, 0, 0, 1'b0);      // R5 neg taken
      run(4'd4, 2'b01, 3, 0, 1'b0);      // R6 neg not taken
      run(4'd0, 2'b00, 0, 0, 1'b1);      // R7 unknown opcode
      run(4'd15, 2'b11, 0, 0, 1'b0);     // R7 unknown opcode
      run(4'd5, 2'b01, 0, 0, 1'b1);      // R7 first code past branches
      run(4'd1, 2'b10, 0, 1, 1'b0);      // R7 fetch after add end

      // reset in the middle of an add routine returns to fetch
      fetch(4'd1, 2'b00, 0, 1'b0);
      cyc(4'd1, 2'b00, 1'b0, A1, "R4");
      rst_n = 1'b0;
      #2;
      check(cw, F1, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      run(4'd2, 2'b00, 0, 0, 1'b0);      // R5 after reset
      run(4'd1, 2'b01, 1, 1, 1'b1);

      @(negedge clk);
      #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule